// File: doc/BRIEF.md
# Miss Fill Buffer Allocator

This block keeps track of L1 data-cache misses that are waiting for their line to come back from the next cache level. It owns a small pool of fill-buffer entries. Each entry holds the line address and whether the request was a demand load or a software prefetch. Both kinds of request draw on the same pool. The pool size is therefore a hard limit on how many misses can be in flight at once. Because an entry is returned as soon as its fill arrives, a shorter fill latency gives higher throughput.

A demand miss that finds no free entry is held back: ready stays low and the requester keeps its request on the inputs. A software prefetch is never held back. It is quietly discarded if any of these is true:
- the pool is full;
- its address faults;
- it targets a line that is already in flight;
- a demand request uses the allocation slot in the same cycle;
- it took a translation miss while the drop-on-translation-miss configuration bit is set.

Each accepted request is issued downstream in the same cycle, tagged with its entry index. The fill response returns that index, and the entry is released.

Top module: `miss_fill_alloc`

## Requirements
- R1: After reset every entry is free (`entry_busy` is all zero), `req_valid` is low and `dmd_ready` is high.
- R2: A demand miss to a line with no live entry, while an entry is free, issues a request in the same cycle. The request carries the lowest-index free entry in `req_idx`, the line in `req_line` and `req_is_pf`=0. The `entry_busy` bit for that index is set from the next cycle.
- R3: At most NUM_ENTRIES (default 10) misses are in flight. Once all entries are busy, no further request is issued until a fill frees one.
- R4: With no free entry and no matching live entry, a demand miss sees `dmd_ready`=0 and no request is issued. The held demand is accepted in the first cycle in which an entry is free, and it takes that entry.
- R5: A demand miss whose line equals that of a live entry merges with it: `dmd_ready`=1, no request is issued and `entry_busy` does not change.
- R6: A software prefetch is accepted when all of these hold: an entry is free, it does not fault, it is not blocked by the translation rule, and no demand is valid in the same cycle. It then issues a request like R2, with `req_is_pf`=1.
- R7: A software prefetch arriving while no entry is free is dropped: no request is issued and `entry_busy` does not change.
- R8: A software prefetch with `pf_fault`=1 is dropped without allocating an entry.
- R9: A software prefetch with `pf_xlat_miss`=1 is dropped when `xlat_drop_en`=1. When `xlat_drop_en`=0 it proceeds as in R6.
- R10: A software prefetch to a line that equals that of a live entry is dropped without allocating.
- R11: When a demand and a prefetch are both valid in one cycle, only the demand may allocate. The prefetch is dropped.
- R12: A `fill_valid` beat whose `fill_idx` names a busy entry frees that entry at the clock edge that samples the beat. The entry can be allocated from the next cycle on. An entry receiving its fill is not counted as live for merging. A fill beat naming a free entry has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_drop_en | input | 1 | When 1, prefetches that took a translation miss are dropped |
| dmd_valid | input | 1 | Demand miss request present |
| dmd_line | input | LINE_W | Line address of the demand miss |
| dmd_ready | output | 1 | Demand accepted this cycle (merged or allocated) |
| pf_valid | input | 1 | Software prefetch request present |
| pf_line | input | LINE_W | Line address of the prefetch |
| pf_fault | input | 1 | Prefetch address faults |
| pf_xlat_miss | input | 1 | Prefetch took a translation miss |
| req_valid | output | 1 | Downstream request issued this cycle |
| req_line | output | LINE_W | Line address of the issued request |
| req_idx | output | IDX_W | Entry index of the issued request |
| req_is_pf | output | 1 | Issued request is a prefetch |
| fill_valid | input | 1 | Fill response beat |
| fill_idx | input | IDX_W | Entry index the fill belongs to |
| entry_busy | output | NUM_ENTRIES | One bit per entry, high while the entry is in flight |

## Verification
The pool is first filled with ten demand misses to distinct lines, which shows that the lowest-free-index order is followed. A demand miss sent into the full pool shows the stall. A demand to a line already held in the full pool shows that merging is told apart from stalling. A fill arriving under a held demand shows that the freed index is the one reused, and a fill on an entry that is the target of a same-cycle demand shows that a filling entry is not merged into. All eight combinations of fault, translation-miss and the configuration bit are applied to a prefetch against an empty pool. The expected outcome is computed arithmetically, which separates the three drop causes from each other. Duplicate-line prefetches and simultaneous demand/prefetch pairs then separate the merge rule and the priority rule from ordinary allocation.

// File: rtl/mfa_pkg.sv
package mfa_pkg;
  typedef enum logic {KIND_DEMAND = 1'b0, KIND_PREFETCH = 1'b1} req_kind_e;

  // A prefetch is refused on its own flags before any pool lookup.
  function automatic logic pf_blocked(input logic fault, input logic xlat_miss,
                                      input logic drop_on_xlat);
    return fault || (xlat_miss && drop_on_xlat);
  endfunction
endpackage

// File: rtl/mfa_pick.sv
module mfa_pick #(
  parameter int N  = 10,
  parameter int IW = 4
) (
  input  logic [N-1:0]  free_v,
  output logic          any_free,
  output logic [IW-1:0] pick_idx
);
  // Lowest-index free entry wins: scan downward so the last hit is the lowest.
  always_comb begin
    pick_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_v[i]) pick_idx = IW'(i);
    end
  end
  assign any_free = |free_v;
endmodule

// File: rtl/mfa_match.sv
module mfa_match #(
  parameter int N  = 10,
  parameter int AW = 26
) (
  input  logic [AW-1:0]   probe,
  input  logic [N*AW-1:0] held_lines,
  input  logic [N-1:0]    live,
  output logic            hit
);
  logic [N-1:0] eq_v;
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign eq_v[i] = live[i] && (held_lines[i*AW +: AW] == probe);
  end
  assign hit = |eq_v;
endmodule

// File: rtl/mfa_store.sv
module mfa_store #(
  parameter int N  = 10,
  parameter int AW = 26,
  parameter int IW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc,
  input  logic [IW-1:0]      alloc_idx,
  input  logic [AW-1:0]      alloc_line,
  input  mfa_pkg::req_kind_e alloc_kind,
  input  logic [N-1:0]       release_v,
  output logic [N-1:0]       busy,
  output logic [N*AW-1:0]    held_lines,
  output logic [N-1:0]       held_pf
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic take;
    assign take = alloc && (alloc_idx == IW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)            busy[i] <= 1'b0;
      else if (take)         busy[i] <= 1'b1;
      else if (release_v[i]) busy[i] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (take) begin
        held_lines[i*AW +: AW] <= alloc_line;
        held_pf[i]             <= (alloc_kind == mfa_pkg::KIND_PREFETCH);
      end
    end
  end
endmodule

// File: rtl/miss_fill_alloc.sv
module miss_fill_alloc #(
  parameter int NUM_ENTRIES = 10,
  parameter int LINE_W      = 26,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   xlat_drop_en,
  input  logic                   dmd_valid,
  input  logic [LINE_W-1:0]      dmd_line,
  output logic                   dmd_ready,
  input  logic                   pf_valid,
  input  logic [LINE_W-1:0]      pf_line,
  input  logic                   pf_fault,
  input  logic                   pf_xlat_miss,
  output logic                   req_valid,
  output logic [LINE_W-1:0]      req_line,
  output logic [IDX_W-1:0]       req_idx,
  output logic                   req_is_pf,
  input  logic                   fill_valid,
  input  logic [IDX_W-1:0]       fill_idx,
  output logic [NUM_ENTRIES-1:0] entry_busy
);
  // Named internal events, also used by the bound checker.
  logic [NUM_ENTRIES-1:0]        busy, fill_hit, live;
  logic [NUM_ENTRIES*LINE_W-1:0] held_lines;
  logic [NUM_ENTRIES-1:0]        held_pf;
  logic                          any_free, dmd_hit, pf_hit;
  logic [IDX_W-1:0]              free_idx;
  logic                          dmd_alloc, pf_alloc, pf_flag_drop;
  mfa_pkg::req_kind_e            alloc_kind;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_fill
    assign fill_hit[i] = fill_valid && (fill_idx == IDX_W'(i)) && busy[i];
  end
  assign live = busy & ~fill_hit;

  mfa_pick #(.N(NUM_ENTRIES), .IW(IDX_W)) u_pick (
    .free_v  (~busy),
    .any_free(any_free),
    .pick_idx(free_idx)
  );

  mfa_match #(.N(NUM_ENTRIES), .AW(LINE_W)) u_dmd_cam (
    .probe(dmd_line), .held_lines(held_lines), .live(live), .hit(dmd_hit)
  );

  mfa_match #(.N(NUM_ENTRIES), .AW(LINE_W)) u_pf_cam (
    .probe(pf_line), .held_lines(held_lines), .live(live), .hit(pf_hit)
  );

  assign pf_flag_drop = mfa_pkg::pf_blocked(pf_fault, pf_xlat_miss, xlat_drop_en);
  assign dmd_alloc    = dmd_valid && !dmd_hit && any_free;
  assign pf_alloc     = pf_valid && !dmd_valid && any_free && !pf_hit && !pf_flag_drop;
  assign alloc_kind   = pf_alloc ? mfa_pkg::KIND_PREFETCH : mfa_pkg::KIND_DEMAND;

  assign dmd_ready  = dmd_hit || any_free;
  assign req_valid  = dmd_alloc || pf_alloc;
  assign req_idx    = free_idx;
  assign req_line   = dmd_valid ? dmd_line : pf_line;
  assign req_is_pf  = pf_alloc;
  assign entry_busy = busy;

  mfa_store #(.N(NUM_ENTRIES), .AW(LINE_W), .IW(IDX_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc     (req_valid),
    .alloc_idx (free_idx),
    .alloc_line(req_line),
    .alloc_kind(alloc_kind),
    .release_v (fill_hit),
    .busy      (busy),
    .held_lines(held_lines),
    .held_pf   (held_pf)
  );
endmodule

// File: rtl/mfa_checker.sv
module mfa_checker #(
  parameter int N  = 10,
  parameter int IW = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dmd_valid,
  input logic         dmd_ready,
  input logic         pf_valid,
  input logic         pf_fault,
  input logic         req_valid,
  input logic         req_is_pf,
  input logic [IW-1:0] req_idx,
  input logic [N-1:0] busy,
  input logic [N-1:0] fill_hit
);
  logic [N-1:0] below_mask, pick_bit;
  always_comb begin
    below_mask = (N'(1) << req_idx) - N'(1);
    pick_bit   = N'(1) << req_idx;
  end

  // R2: the issued index is free and every lower index is busy.
  p_lowest_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (((busy & below_mask) == below_mask) && ((busy & pick_bit) == '0)));

  // R2: an issued entry is busy in the following cycle.
  p_alloc_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ((busy & $past(pick_bit)) != '0));

  // R3: a full pool issues nothing.
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy) |-> !req_valid);

  // R4: a stalled demand issues nothing.
  p_stall_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dmd_valid && !dmd_ready) |-> !req_valid);

  // R8: faulting prefetch never allocates.
  p_fault_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_fault) |-> !(req_valid && req_is_pf));

  // R11: demand owns the slot when both are valid.
  p_demand_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && dmd_valid) |-> !(req_valid && req_is_pf));

  // R12: a filled entry is free in the next cycle.
  p_fill_frees_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|fill_hit) |=> ((busy & $past(fill_hit)) == '0));
endmodule

bind miss_fill_alloc mfa_checker #(.N(NUM_ENTRIES), .IW(IDX_W)) u_mfa_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dmd_valid(dmd_valid),
  .dmd_ready(dmd_ready),
  .pf_valid (pf_valid),
  .pf_fault (pf_fault),
  .req_valid(req_valid),
  .req_is_pf(req_is_pf),
  .req_idx  (req_idx),
  .busy     (busy),
  .fill_hit (fill_hit)
);

// File: tb/tb_miss_fill_alloc.sv
module tb_miss_fill_alloc;
  localparam int N  = 10;
  localparam int AW = 26;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic xlat_drop_en, dmd_valid, pf_valid, pf_fault, pf_xlat_miss, fill_valid;
  logic [AW-1:0] dmd_line, pf_line;
  logic [IW-1:0] fill_idx;
  logic dmd_ready, req_valid, req_is_pf;
  logic [AW-1:0] req_line;
  logic [IW-1:0] req_idx;
  logic [N-1:0]  entry_busy;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  miss_fill_alloc #(.NUM_ENTRIES(N), .LINE_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .xlat_drop_en(xlat_drop_en),
    .dmd_valid(dmd_valid), .dmd_line(dmd_line), .dmd_ready(dmd_ready),
    .pf_valid(pf_valid), .pf_line(pf_line), .pf_fault(pf_fault),
    .pf_xlat_miss(pf_xlat_miss), .req_valid(req_valid), .req_line(req_line),
    .req_idx(req_idx), .req_is_pf(req_is_pf), .fill_valid(fill_valid),
    .fill_idx(fill_idx), .entry_busy(entry_busy)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Apply inputs after a falling edge, settle, leave sampling to the caller.
  task automatic drive(input logic dv, input logic [AW-1:0] dl,
                       input logic pv, input logic [AW-1:0] pl,
                       input logic pfa, input logic pxm,
                       input logic fv, input logic [IW-1:0] fi);
    @(negedge clk);
    dmd_valid = dv; dmd_line = dl; pf_valid = pv; pf_line = pl;
    pf_fault = pfa; pf_xlat_miss = pxm; fill_valid = fv; fill_idx = fi;
    #1;
  endtask

  task automatic idle();
    drive(0, '0, 0, '0, 0, 0, 0, '0);
  endtask

  initial begin
    #2000000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; xlat_drop_en = 0;
    dmd_valid = 0; dmd_line = '0; pf_valid = 0; pf_line = '0;
    pf_fault = 0; pf_xlat_miss = 0; fill_valid = 0; fill_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    chk("R1 busy", entry_busy, 0);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 dmd_ready", dmd_ready, 1);

    // R2/R3: fill the pool in index order.
    for (int k = 0; k < N; k++) begin
      drive(1, AW'(32'h100 + k), 0, '0, 0, 0, 0, '0);
      chk("R2 req_valid", req_valid, 1);
      chk("R2 req_idx", req_idx, k);
      chk("R2 req_line", req_line, 32'h100 + k);
      chk("R2 req_is_pf", req_is_pf, 0);
    end
    idle();
    chk("R3 all busy", entry_busy, (1 << N) - 1);

    // R4: stall on a full pool; R7: prefetch dropped on a full pool.
    drive(1, AW'(32'h200), 0, '0, 0, 0, 0, '0);
    chk("R4 ready low", dmd_ready, 0);
    chk("R4 no req", req_valid, 0);
    drive(0, '0, 1, AW'(32'h300), 0, 0, 0, '0);
    chk("R7 no req", req_valid, 0);
    idle();
    chk("R7 busy unchanged", entry_busy, (1 << N) - 1);

    // R5: merge with a held line while full.
    drive(1, AW'(32'h105), 0, '0, 0, 0, 0, '0);
    chk("R5 ready", dmd_ready, 1);
    chk("R5 no req", req_valid, 0);
    idle();
    chk("R5 busy unchanged", entry_busy, (1 << N) - 1);

    // R4/R12: held demand takes the entry freed by a fill.
    drive(1, AW'(32'h200), 0, '0, 0, 0, 1, IW'(6));
    chk("R4 still stalled during fill", dmd_ready, 0);
    drive(1, AW'(32'h200), 0, '0, 0, 0, 0, '0);
    chk("R4 held accepted", req_valid, 1);
    chk("R4 reuses freed idx", req_idx, 6);

    // R12: filling entry is not merged into.
    drive(1, AW'(32'h103), 0, '0, 0, 0, 1, IW'(3));
    chk("R12 no merge into filling entry", dmd_ready, 0);
    idle();
    chk("R12 entry freed", entry_busy, ((1 << N) - 1) & ~(1 << 3));
    drive(1, AW'(32'h103), 0, '0, 0, 0, 0, '0);
    chk("R12 realloc idx", req_idx, 3);
    chk("R12 realloc valid", req_valid, 1);

    // R12: release everything, then a fill on a free entry.
    for (int k = 0; k < N; k++) drive(0, '0, 0, '0, 0, 0, 1, IW'(k));
    idle();
    chk("R12 all released", entry_busy, 0);
    drive(0, '0, 0, '0, 0, 0, 1, IW'(5));
    idle();
    chk("R12 stray fill no effect", entry_busy, 0);

    // R6/R8/R9: sweep fault, translation miss and config bit.
    for (int c = 0; c < 8; c++) begin
      bit fa, xm, cf, exp_alloc;
      fa = c[0]; xm = c[1]; cf = c[2];
      exp_alloc = !fa && !(xm && cf);
      @(negedge clk) xlat_drop_en = cf;
      drive(0, '0, 1, AW'(32'h400 + c), fa, xm, 0, '0);
      chk("R6 R8 R9 pf req_valid", req_valid, exp_alloc);
      if (exp_alloc) begin
        chk("R6 pf kind", req_is_pf, 1);
        chk("R6 pf idx", req_idx, 0);
      end
      idle();
      chk("R8 R9 busy after pf", entry_busy, exp_alloc);
      if (exp_alloc) drive(0, '0, 0, '0, 0, 0, 1, IW'(0));
    end
    xlat_drop_en = 0;
    idle();

    // R10: duplicate prefetch dropped, distinct one allocates.
    drive(1, AW'(32'h500), 0, '0, 0, 0, 0, '0);
    chk("R10 setup idx", req_idx, 0);
    drive(0, '0, 1, AW'(32'h500), 0, 0, 0, '0);
    chk("R10 dup dropped", req_valid, 0);
    drive(0, '0, 1, AW'(32'h501), 0, 0, 0, '0);
    chk("R6 distinct pf", req_valid, 1);
    chk("R6 distinct pf idx", req_idx, 1);

    // R11: demand beats prefetch in the same cycle.
    drive(1, AW'(32'h600), 1, AW'(32'h601), 0, 0, 0, '0);
    chk("R11 demand issued", req_is_pf, 0);
    chk("R11 idx", req_idx, 2);
    chk("R11 line", req_line, 32'h600);
    idle();
    chk("R11 pf not allocated", entry_busy, 3'b111);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule